// File: doc/BRIEF.md
# Dual-Port Strobed Event Reader with Fill Substitution

This block hands the most recent 32-bit event word to an external encoder that reads it through two separate 16-bit output ports. Each port has its own read strobe. The encoder raises a port's strobe to ask for data and captures the port on the falling edge of that strobe. For every word it reads the lower-half port first and the upper-half port second.

An upstream source loads event words with a one-cycle valid pulse. When the lower-half read starts, the block decides between the stored event and a fixed fill constant. A static strap input picks which of two constants is used. The upper-half read always shows the other half of that same decision. A stored event counts as consumed only once the upper-half strobe falls. An event that arrives part-way through a read stays pending for the next read.

Both strobes are asynchronous to the block clock and pass through a synchronizer. The output registers change only after a detected rising strobe edge. They hold their value through the falling edge, so the encoder captures settled data.

Top module: `dual_port_strobe_reader`

## Requirements
- R1: After reset both ports read 0 and no event is pending, so the first read returns fill.
- R2: After a rising edge of `rd_lo_strb`, `port_lo` shows bits 15:0 of the selected word within 6 clock cycles. It then stays unchanged, including across the falling edge, until the next rising edge of `rd_lo_strb`.
- R3: After a rising edge of `rd_hi_strb`, `port_hi` shows bits 31:16 of the word selected at the most recent rising edge of `rd_lo_strb`, within 6 clock cycles. It stays unchanged until the next rising edge of `rd_hi_strb`.
- R4: If an event is pending at the rising edge of `rd_lo_strb`, the selected word is that event word. Otherwise the selected word is the fill constant.
- R5: The fill constant is 0x9C969593 when `fill_sel` is 0 and 0xACA6A5A3 when `fill_sel` is 1. `fill_sel` is sampled at the rising edge of `rd_lo_strb`.
- R6: A pending event that was selected is consumed at the falling edge of `rd_hi_strb`. A following read with no new event returns fill.
- R7: An event that arrives after the lower-half read has begun and before the upper-half strobe falls does not appear on `port_hi` for the current word. It is not consumed, and the next read returns it.
- R8: When several events arrive before a read, the last one is returned.
- R9: A `rd_hi_strb` pulse with no lower-half read before it shows the upper half of the last selected word and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | One-cycle pulse that loads `evt_data` |
| evt_data | input | 32 | Event word |
| fill_sel | input | 1 | Static strap that picks the fill constant |
| rd_lo_strb | input | 1 | Asynchronous read strobe for the lower-half port, active high |
| rd_hi_strb | input | 1 | Asynchronous read strobe for the upper-half port, active high |
| port_lo | output | 16 | Event bits 15:0 |
| port_hi | output | 16 | Event bits 31:16 |

## Verification
The bench goes after the cases where the two halves could come from different words. One is an event injected between the two strobes; a design that re-decides at the upper-half read would return a torn word. Another is an event that arrives mid-read and is wrongly marked consumed, which a design clearing on any upper-half falling edge would lose silently. The bench also covers an upper-half strobe with no lower-half read before it, a burst of events before one read, and both fill settings. A design that updates the port on the falling strobe edge would show data changing across the capture edge.

// File: rtl/dpsr_pkg.sv
// Shared constants and helpers for the dual-port strobed reader.
// Assumes a 32-bit event word split into two 16-bit halves.
package dpsr_pkg;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int NUM_PORTS = 2;

    localparam logic [WORD_W-1:0] FILL_A = 32'h9C96_9593;
    localparam logic [WORD_W-1:0] FILL_B = 32'hACA6_A5A3;

    // Return the fill constant picked by the strap.
    function automatic logic [WORD_W-1:0] fill_word(input logic sel);
        return sel ? FILL_B : FILL_A;
    endfunction
endpackage

// File: rtl/dpsr_strobe_sync.sv
// Brings one asynchronous strobe into the clock domain and flags its edges.
// Assumes each strobe level lasts longer than STAGES+1 clock cycles.
module dpsr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_async,
    output logic lead,
    output logic trail
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the raw strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], strb_async};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign lead  =  chain[STAGES-1] & ~last;
    assign trail = ~chain[STAGES-1] &  last;
endmodule

// File: rtl/dpsr_event_hold.sv
// Stores the latest event, decides event-or-fill at each lower-half read and
// tracks when the event has been consumed.
// Assumes snap (lower-half lead) and release (upper-half trail) come from
// separate strobes; if both fire together, snap takes priority for the selection.
module dpsr_event_hold
    import dpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [WORD_W-1:0] evt_data,
    input  logic              fill_sel,
    input  logic              snap,
    input  logic              release_rd,
    output logic [WORD_W-1:0] cur_word
);
    logic [WORD_W-1:0] stored;
    logic              pending;
    logic              taken;
    logic              newer;

    // Capture the newest event word.
    always_ff @(posedge clk) begin
        if (!rst_n)         stored <= '0;
        else if (evt_valid) stored <= evt_data;
    end

    // Select event or fill at the lower-half read and record whether an event was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word <= '0;
            taken    <= 1'b0;
        end else if (snap) begin
            cur_word <= pending ? stored : fill_word(fill_sel);
            taken    <= pending;
        end else if (release_rd) begin
            taken    <= 1'b0;
        end
    end

    // Note events that arrive while a word read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)         newer <= 1'b0;
        else if (snap)      newer <= evt_valid;
        else if (evt_valid) newer <= 1'b1;
    end

    // Set pending on every event; clear it when the taken word finishes its read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pending <= 1'b0;
        else if (evt_valid)                           pending <= 1'b1;
        else if (release_rd && taken && !newer && !snap) pending <= 1'b0;
    end

    // R4: a pending event is what the read selects
    a_r4_event_selected: assert property (@(posedge clk) disable iff (!rst_n)
        snap && pending |=> cur_word == $past(stored));
    // R5: with nothing pending the strap-chosen fill is selected
    a_r5_fill_selected: assert property (@(posedge clk) disable iff (!rst_n)
        snap && !pending |=> (cur_word == FILL_A || cur_word == FILL_B));
    // R6: pending is only cleared at an upper-half falling edge
    a_r6_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(release_rd));
    // R7: an event newer than the selection survives the release
    a_r7_newer_kept: assert property (@(posedge clk) disable iff (!rst_n)
        release_rd && newer |=> pending);
endmodule

// File: rtl/dpsr_port_stage.sv
// Output register for one half-word port; loads only when told to.
// Assumes load pulses for one cycle after a detected rising strobe edge.
module dpsr_port_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Hold the port value between loads.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/dual_port_strobe_reader.sv
// Top level: presents the selected 32-bit word as a lower-half and an
// upper-half port, each updated on the rising edge of its own strobe.
// Assumes the encoder reads the lower half before the upper half.
module dual_port_strobe_reader
    import dpsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [WORD_W-1:0] evt_data,
    input  logic              fill_sel,
    input  logic              rd_lo_strb,
    input  logic              rd_hi_strb,
    output logic [HALF_W-1:0] port_lo,
    output logic [HALF_W-1:0] port_hi
);
    logic [NUM_PORTS-1:0] strb_raw;
    logic [NUM_PORTS-1:0] lead;
    logic [NUM_PORTS-1:0] trail;
    logic [NUM_PORTS-1:0] load_q;
    logic [WORD_W-1:0]    cur_word;
    logic [HALF_W-1:0]    pdata [NUM_PORTS];

    assign strb_raw = {rd_hi_strb, rd_lo_strb};

    dpsr_event_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_data  (evt_data),
        .fill_sel  (fill_sel),
        .snap      (lead[0]),
        .release_rd(trail[1]),
        .cur_word  (cur_word)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpsr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .strb_async(strb_raw[p]),
            .lead      (lead[p]),
            .trail     (trail[p])
        );

        // Delay the load by one cycle so the lower half sees the new selection.
        always_ff @(posedge clk) begin
            if (!rst_n) load_q[p] <= 1'b0;
            else        load_q[p] <= lead[p];
        end

        dpsr_port_stage #(.WIDTH(HALF_W)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load_q[p]),
            .din  (cur_word[p*HALF_W +: HALF_W]),
            .dout (pdata[p])
        );
    end

    assign port_lo = pdata[0];
    assign port_hi = pdata[1];

    // R2: the lower-half port never moves without a rising lower-half strobe
    a_r2_lo_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_q[0]) |-> $stable(port_lo));
    // R3: the upper-half port never moves without a rising upper-half strobe
    a_r3_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_q[1]) |-> $stable(port_hi));
    // R3: upper half comes from the same selection as the lower half
    a_r3_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        load_q[1] && !lead[0] |=> port_hi == cur_word[WORD_W-1:HALF_W]);
endmodule

// File: tb/dual_port_strobe_reader_tb.sv
module dual_port_strobe_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [31:0] evt_data = '0;
    logic        fill_sel = 1'b0;
    logic        rd_lo_strb = 1'b0;
    logic        rd_hi_strb = 1'b0;
    logic [15:0] port_lo, port_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model, written from the requirements
    bit          m_pend = 0;
    logic [31:0] m_stored = '0;
    logic [31:0] m_snap = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_port_strobe_reader u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_data(evt_data),
        .fill_sel(fill_sel), .rd_lo_strb(rd_lo_strb), .rd_hi_strb(rd_hi_strb),
        .port_lo(port_lo), .port_hi(port_hi)
    );

    function automatic logic [31:0] fill_of(input logic s);
        return s ? 32'hACA6A5A3 : 32'h9C969593;
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_event(input logic [31:0] w);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_data  = w;
        @(negedge clk);
        evt_valid = 1'b0;
        m_stored = w;
        m_pend   = 1;
    endtask

    // Full two-port read; optionally injects an event between the halves (R7).
    task automatic read_word(input string tag, input bit inject, input logic [31:0] mid);
        bit taken, newer;
        m_snap = m_pend ? m_stored : fill_of(fill_sel);
        taken = m_pend;
        newer = 0;
        @(negedge clk); rd_lo_strb = 1'b1;
        wait_cyc(SETTLE);
        check16({tag, " R2 lo after lead"}, port_lo, m_snap[15:0]);
        if (inject) begin
            send_event(mid);
            newer = 1;
        end
        rd_lo_strb = 1'b0;
        wait_cyc(SETTLE);
        check16({tag, " R2 lo held past trail"}, port_lo, m_snap[15:0]);
        rd_hi_strb = 1'b1;
        wait_cyc(SETTLE);
        check16({tag, " R3 hi same word"}, port_hi, m_snap[31:16]);
        rd_hi_strb = 1'b0;
        wait_cyc(SETTLE);
        check16({tag, " R3 hi held past trail"}, port_hi, m_snap[31:16]);
        if (taken && !newer) m_pend = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        check16("R1 reset lo", port_lo, 16'h0);
        check16("R1 reset hi", port_hi, 16'h0);
        read_word("R1 R5 first read is fill", 0, '0);
        check16("R1 fill lo", port_lo, 16'h9593);

        for (int s = 0; s < 2; s++) begin
            fill_sel = s[0];
            for (int i = 0; i < 12; i++) begin
                logic [31:0] w;
                w = (32'h1357_9BDF * (i + 1)) ^ (32'hF0E1_D2C3 >> i) ^ {s[15:0], 16'h0};
                // R4 plain event read
                send_event(w);
                read_word("R4 event", 0, '0);
                check16("R4 event lo value", port_lo, w[15:0]);
                // R6 consumed: next read is fill (R5)
                read_word("R6 R5 after consume", 0, '0);
                check16("R5 fill hi value", port_hi, fill_of(fill_sel) >> 16);
                // R8 burst, last wins
                send_event(~w);
                send_event(w + 32'h0101_0101);
                read_word("R8 burst", 0, '0);
                check16("R8 latest hi", port_hi, (w + 32'h0101_0101) >> 16);
                // R7 mid-read event kept for next read
                read_word("R7 mid inject", 1, w ^ 32'h5A5A_A5A5);
                read_word("R7 next read returns it", 0, '0);
                check16("R7 held word lo", port_lo, w[15:0] ^ 16'hA5A5);
                // R9 upper-half-only pulse
                send_event(w ^ 32'h0F0F_F0F0);
                @(negedge clk); rd_hi_strb = 1'b1;
                wait_cyc(SETTLE);
                check16("R9 hi only shows last word", port_hi, m_snap[31:16]);
                rd_hi_strb = 1'b0;
                wait_cyc(SETTLE);
                read_word("R9 event not consumed", 0, '0);
                check16("R9 pending event returned", port_hi, (w ^ 32'h0F0F_F0F0) >> 16);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule